// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the bus side of a three-channel programmable interval timer. A host reaches it through an 8-bit register port with a 2-bit address. Addresses 0, 1 and 2 are the data ports of the three counters, and address 3 is the control port. Writes to the control port configure a channel, freeze a channel's live count, or run a read-back command that can freeze the count, the status or both on any set of channels at once. Writes to a data port assemble a 16-bit count, one or two bytes at a time. When the count is complete, the block sends it to that channel's counting element together with a one-cycle load strobe.

Reads from a data port return, in order of precedence, a frozen status byte, then a frozen count, then the live count that the counting element supplies. Each channel has its own byte sequencers, so the byte order follows that channel's access setting. The counting engines lie outside this block. They provide a live count, an OUT level and an acknowledge that a loaded count has been taken. The bus is always ready and has no back-pressure. A strobe is accepted in the cycle it is high. Read data and its valid flag appear in the following cycle. A read and a write never arrive in the same cycle.

Top module: `tmr_bus_regif`

## Requirements
- R1: On a control-port write, bits 7:6 pick channel 0, 1 or 2. The value 3 in that field marks a read-back command, which configures no channel.
- R2: A control word with a non-zero access field (bits 5:4) stores the access setting, the counting mode from bits 3:1 and the BCD flag from bit 0. Mode codes 6 and 7 are stored as 2 and 3. The word also returns both byte sequencers of that channel to the low byte. Out of reset every channel has access 1, mode 0 and BCD 0.
- R3: A control word whose access field is 0 freezes that channel's live count and leaves its configuration unchanged. Later reads return the frozen bytes in the order set by the access setting (1: low byte only, 2: high byte only, 3: low byte then high byte). After that the channel returns to live reads.
- R4: In a read-back command, bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 at 0 freezes the count and bit 4 at 0 freezes the status.
- R5: A request to freeze the count or the status is ignored while an earlier frozen value of the same kind has not been fully read.
- R6: The status byte carries OUT in bit 7, the null-count flag in bit 6, the access setting in bits 5:4, the mode in bits 3:1 and BCD in bit 0. All fields are taken at the moment of the freeze.
- R7: A data write with access 1 loads the count 0x00 followed by the byte. With access 2 it loads the byte followed by 0x00.
- R8: With access 3, the first data write only holds the byte as the low half. The second write loads the count {byte, held byte}, and the sequence then expects a low byte again.
- R9: A data read returns a frozen status first and releases it. If no status is frozen, the read returns a frozen count. If neither is frozen, it returns the live count.
- R10: A live read returns the low byte with access 1 and the high byte with access 2. With access 3, successive reads alternate low, high, low, and so on.
- R11: The null-count flag of a channel is set by a control word or a completed count load on that channel. It is cleared by the counting element's loaded acknowledge, and a set in the same cycle takes precedence over the clear.
- R12: Read data and its valid flag appear in the cycle after the read strobe, and the valid flag is low in every other cycle. A read at the control address returns 0x00.
- R13: A load strobe is one cycle long and appears in the cycle after the write that completes a count, on that channel only. Control writes never cause a load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 2 | 0 to 2: counter data ports, 3: control port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle after bus_rd |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| ch_live | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| ch_out | input | 3 | OUT level of each channel |
| ch_loaded | input | 3 | Per-channel acknowledge that the loaded count has been taken |
| ch_load_stb | output | 3 | Per-channel one-cycle count load strobe |
| ch_load_val | output | 48 | Per-channel 16-bit count to load, channel 0 in the low bits |

## Verification
The bench builds the block with its default of three channels. With that setting every legal control word can be swept: each channel, each non-zero access setting, all eight mode codes and both BCD values. Each combination is read back as a frozen status byte and compared with a value computed from the field layout, which includes the folding of modes 6 and 7. Fixed live counts chosen per channel make every byte order checkable. These cover live reads, frozen counts in all three access settings, status-before-count precedence, the ignored second freeze and multi-channel read-back.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FRZ_NONE = 2'd0,
    FRZ_LO   = 2'd1,
    FRZ_HI   = 2'd2,
    FRZ_BOTH = 2'd3
  } frz_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ch_cfg_t;
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output ch_cfg_t           new_cfg,
  output logic [NUM_CH-1:0] cfg_wr,
  output logic [NUM_CH-1:0] cnt_frz_req,
  output logic [NUM_CH-1:0] st_frz_req,
  output logic [NUM_CH-1:0] data_wr
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  logic       ctl_wr;
  logic       rb_cmd;
  logic [2:0] raw_mode;

  assign ctl_wr   = wr_en && (addr == CTRL_ADDR);
  assign rb_cmd   = (wdata[7:6] == 2'd3);
  assign raw_mode = wdata[3:1];

  always_comb begin
    new_cfg.acc  = acc_e'(wdata[5:4]);
    new_cfg.mode = (raw_mode[2] && raw_mode[1]) ? {1'b0, raw_mode[1:0]} : raw_mode;
    new_cfg.bcd  = wdata[0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic pick;
    assign pick           = ctl_wr && !rb_cmd && (wdata[7:6] == 2'(g));
    assign cfg_wr[g]      = pick && (wdata[5:4] != ACC_LATCH);
    assign cnt_frz_req[g] = (pick && (wdata[5:4] == ACC_LATCH)) ||
                            (ctl_wr && rb_cmd && wdata[g+1] && !wdata[5]);
    assign st_frz_req[g]  = ctl_wr && rb_cmd && wdata[g+1] && !wdata[4];
    assign data_wr[g]     = wr_en && (addr == ADDR_W'(g));
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ch_cfg_t           new_cfg,
  input  logic              cfg_wr,
  input  logic              cnt_frz_req,
  input  logic              st_frz_req,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_req,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  input  logic              loaded_ack,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val
);
  ch_cfg_t           cfg_q;
  logic              wr_hi, rd_hi;
  logic [BYTE_W-1:0] lo_hold;
  logic              null_q;
  logic              st_full;
  logic [BYTE_W-1:0] st_q;
  frz_e              frz_st;
  logic [CNT_W-1:0]  frz_cnt;
  logic              load_evt;

  assign load_evt = data_wr && !(cfg_q.acc == ACC_WORD && !wr_hi);

  // configuration and write-side byte sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '{acc: ACC_LO, mode: 3'd0, bcd: 1'b0};
      wr_hi    <= 1'b0;
      lo_hold  <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;
      if (cfg_wr) begin
        cfg_q <= new_cfg;
        wr_hi <= 1'b0;
      end else if (data_wr) begin
        unique case (cfg_q.acc)
          ACC_HI: begin
            load_stb <= 1'b1;
            load_val <= {wdata, {BYTE_W{1'b0}}};
          end
          ACC_WORD: begin
            if (wr_hi) begin
              load_stb <= 1'b1;
              load_val <= {wdata, lo_hold};
              wr_hi    <= 1'b0;
            end else begin
              lo_hold <= wdata;
              wr_hi   <= 1'b1;
            end
          end
          default: begin
            load_stb <= 1'b1;
            load_val <= {{BYTE_W{1'b0}}, wdata};
          end
        endcase
      end
    end
  end

  // null-count flag
  always_ff @(posedge clk) begin
    if (!rst_n)                  null_q <= 1'b0;
    else if (cfg_wr || load_evt) null_q <= 1'b1;
    else if (loaded_ack)         null_q <= 1'b0;
  end

  // read data selection
  always_comb begin
    if (st_full) begin
      rd_byte = st_q;
    end else begin
      unique case (frz_st)
        FRZ_LO, FRZ_BOTH: rd_byte = frz_cnt[BYTE_W-1:0];
        FRZ_HI:           rd_byte = frz_cnt[CNT_W-1:BYTE_W];
        default: begin
          if (cfg_q.acc == ACC_HI || (cfg_q.acc == ACC_WORD && rd_hi))
            rd_byte = live_cnt[CNT_W-1:BYTE_W];
          else
            rd_byte = live_cnt[BYTE_W-1:0];
        end
      endcase
    end
  end

  // status freeze, count freeze and read-side sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_full <= 1'b0;
      st_q    <= '0;
      frz_st  <= FRZ_NONE;
      frz_cnt <= '0;
      rd_hi   <= 1'b0;
    end else begin
      if (cfg_wr) rd_hi <= 1'b0;
      if (st_frz_req && !st_full) begin
        st_full <= 1'b1;
        st_q    <= {out_lvl, null_q, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
      end
      if (cnt_frz_req && frz_st == FRZ_NONE) begin
        frz_cnt <= live_cnt;
        unique case (cfg_q.acc)
          ACC_HI:   frz_st <= FRZ_HI;
          ACC_WORD: frz_st <= FRZ_BOTH;
          default:  frz_st <= FRZ_LO;
        endcase
      end
      if (rd_req) begin
        if (st_full)                   st_full <= 1'b0;
        else if (frz_st == FRZ_BOTH)   frz_st  <= FRZ_HI;
        else if (frz_st != FRZ_NONE)   frz_st  <= FRZ_NONE;
        else if (cfg_q.acc == ACC_WORD) rd_hi  <= !rd_hi;
      end
    end
  end

  AST_STB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(data_wr)); // R13
  AST_WORD_LOW_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cfg_q.acc == ACC_WORD && !wr_hi) |=> !load_stb); // R8
  AST_FREEZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_frz_req && frz_st != FRZ_NONE) |=> $stable(frz_cnt)); // R5
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && st_full) |=> (!st_full && $stable(frz_st))); // R9
  AST_NULL_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> null_q); // R11
endmodule

// File: rtl/tmr_bus_regif.sv
module tmr_bus_regif
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [1:0]              bus_addr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    bus_rvalid,
  input  logic [NUM_CH*16-1:0]    ch_live,
  input  logic [NUM_CH-1:0]       ch_out,
  input  logic [NUM_CH-1:0]       ch_loaded,
  output logic [NUM_CH-1:0]       ch_load_stb,
  output logic [NUM_CH*16-1:0]    ch_load_val
);
  localparam int ADDR_W = 2;

  ch_cfg_t           new_cfg;
  logic [NUM_CH-1:0] cfg_wr, cnt_frz_req, st_frz_req, data_wr;
  logic [BYTE_W-1:0] rd_byte [NUM_CH];
  logic [BYTE_W-1:0] rd_sel;

  tmr_ctrl_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .new_cfg     (new_cfg),
    .cfg_wr      (cfg_wr),
    .cnt_frz_req (cnt_frz_req),
    .st_frz_req  (st_frz_req),
    .data_wr     (data_wr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_chan_port u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .new_cfg     (new_cfg),
      .cfg_wr      (cfg_wr[g]),
      .cnt_frz_req (cnt_frz_req[g]),
      .st_frz_req  (st_frz_req[g]),
      .data_wr     (data_wr[g]),
      .wdata       (bus_wdata),
      .rd_req      (bus_rd && (bus_addr == ADDR_W'(g))),
      .live_cnt    (ch_live[g*CNT_W +: CNT_W]),
      .out_lvl     (ch_out[g]),
      .loaded_ack  (ch_loaded[g]),
      .rd_byte     (rd_byte[g]),
      .load_stb    (ch_load_stb[g]),
      .load_val    (ch_load_val[g*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_addr == ADDR_W'(i)) rd_sel = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_sel;
    end
  end

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R12
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rvalid && bus_rdata == 8'h00)); // R12
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_stb)); // R13
endmodule

// File: tb/tmr_bus_regif_tb.sv
module tmr_bus_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [15:0] live [3];
  logic [47:0] ch_live;
  logic [2:0]  ch_out = '0, ch_loaded = '0;
  logic [2:0]  ch_load_stb;
  logic [47:0] ch_load_val;
  logic [2:0]  last_stb;
  logic [47:0] last_val;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  assign ch_live = {live[2], live[1], live[0]};

  tmr_bus_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_live(ch_live), .ch_out(ch_out),
    .ch_loaded(ch_loaded), .ch_load_stb(ch_load_stb), .ch_load_val(ch_load_val)
  );

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    last_stb = ch_load_stb; last_val = ch_load_val;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk("R12 read valid", {47'd0, bus_rvalid}, 48'd1);
    chk(tag, {40'd0, bus_rdata}, {40'd0, exp});
  endtask

  task automatic ack(input int ch);
    @(negedge clk); ch_loaded[ch] = 1'b1;
    @(negedge clk); ch_loaded = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    live[0] = 16'h0; live[1] = 16'h0; live[2] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rvalid", {47'd0, bus_rvalid}, 48'd0);
    chk("R12 reset rdata", {40'd0, bus_rdata}, 48'd0);
    chk("R13 reset strobe", {45'd0, ch_load_stb}, 48'd0);
    wr(2'd3, 8'hE8);                       // status freeze, channel 2
    rd(2'd2, 8'h10, "R2 reset config status");

    // sweep of every legal control word
    for (int ch = 0; ch < 3; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            logic [2:0] mexp;
            logic       o;
            o = 1'(m ^ b ^ ch);
            ch_out[ch] = o;
            wr(2'd3, 8'((ch << 6) | (acc << 4) | (m << 1) | b));
            chk("R13 no load on control", {45'd0, last_stb}, 48'd0);
            wr(2'd3, 8'(8'hE0 | (1 << (ch + 1))));
            mexp = (m >= 6) ? 3'(m - 4) : 3'(m);
            rd(2'(ch), {o, 1'b1, 2'(acc), mexp, 1'(b)}, "R1 R2 R4 R6 status sweep");
          end
    ch_out = '0;

    // null count
    wr(2'd3, 8'h10);
    ack(0);
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h10, "R11 null cleared by ack");
    wr(2'd0, 8'h22);
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h50, "R11 null set by load");

    // count writes
    wr(2'd3, 8'h50);
    wr(2'd1, 8'h5A);
    chk("R13 strobe lsb", {45'd0, last_stb}, 48'd2);
    chk("R7 lsb value", {32'd0, last_val[31:16]}, 48'h005A);
    wr(2'd3, 8'h60);
    wr(2'd1, 8'hA5);
    chk("R7 msb value", {32'd0, last_val[31:16]}, 48'hA500);
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h34);
    chk("R8 no load on low byte", {45'd0, last_stb}, 48'd0);
    wr(2'd1, 8'h12);
    chk("R8 strobe high byte", {45'd0, last_stb}, 48'd2);
    chk("R8 word value", {32'd0, last_val[31:16]}, 48'h1234);
    wr(2'd1, 8'h78);
    chk("R8 sequence restarts", {45'd0, last_stb}, 48'd0);
    wr(2'd1, 8'h56);
    chk("R8 second word", {32'd0, last_val[31:16]}, 48'h5678);

    // live reads
    live[2] = 16'hBEEF;
    wr(2'd3, 8'h90); rd(2'd2, 8'hEF, "R10 live lsb");
    wr(2'd3, 8'hA0); rd(2'd2, 8'hBE, "R10 live msb");
    wr(2'd3, 8'hB0);
    rd(2'd2, 8'hEF, "R10 live word low");
    rd(2'd2, 8'hBE, "R10 live word high");
    rd(2'd2, 8'hEF, "R10 live word low again");
    wr(2'd3, 8'hB0);
    rd(2'd2, 8'hEF, "R2 control resets read sequence");

    // counter latch command
    wr(2'd3, 8'h30);
    live[0] = 16'h1357;
    wr(2'd3, 8'h00);
    live[0] = 16'h2468;
    wr(2'd3, 8'h00);
    rd(2'd0, 8'h57, "R3 frozen low");
    rd(2'd0, 8'h13, "R5 second freeze ignored");
    rd(2'd0, 8'h68, "R9 live after release");
    rd(2'd0, 8'h24, "R10 live high");
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h70, "R3 config unchanged");

    // read-back of status and count together
    live[0] = 16'hCAFE;
    wr(2'd3, 8'hC2);
    rd(2'd0, 8'h70, "R9 status first");
    rd(2'd0, 8'hFE, "R4 frozen low");
    rd(2'd0, 8'hCA, "R4 frozen high");
    wr(2'd3, 8'hE2);
    ch_out[0] = 1'b1;
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h70, "R5 status freeze ignored");
    rd(2'd0, 8'hFE, "R9 live after status");
    ch_out = '0;

    // multi-channel count read-back
    live[1] = 16'h4321; live[2] = 16'h8765;
    wr(2'd3, 8'hDC);
    live[1] = 16'h0; live[2] = 16'h0;
    rd(2'd1, 8'h21, "R4 channel 1 low");
    rd(2'd1, 8'h43, "R4 channel 1 high");
    rd(2'd2, 8'h65, "R4 channel 2 low");
    rd(2'd2, 8'h87, "R4 channel 2 high");

    // lsb-only and msb-only freezes
    live[2] = 16'h8765;
    wr(2'd3, 8'h90);
    wr(2'd3, 8'h80);
    live[2] = 16'h1111;
    rd(2'd2, 8'h65, "R3 frozen lsb only");
    rd(2'd2, 8'h11, "R3 live after lsb freeze");
    wr(2'd3, 8'hA0);
    wr(2'd3, 8'h80);
    live[2] = 16'h2222;
    rd(2'd2, 8'h11, "R3 frozen msb only");
    rd(2'd2, 8'h22, "R3 live after msb freeze");

    // control port read and idle valid
    rd(2'd3, 8'h00, "R12 control read zero");
    @(negedge clk);
    chk("R12 idle valid low", {47'd0, bus_rvalid}, 48'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule